// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block decides whether a 512-byte sector read from flash is intact. It compares the 24-bit Hamming code kept in the spare area against the code computed again over the data as it was read. The spare-area copy is stored inverted, so the block complements it before the comparison. Each 24-bit code is split into two 12-bit halves. The lower half holds bits [11:0], which are byte 0 together with the low nibble of byte 1. The upper half holds bits [23:12], which are the high nibble of byte 1 together with byte 2. XOR-ing the matching halves of the two codes gives an odd syndrome and an even syndrome.

The two syndromes place the outcome in one of four classes:
- No error: both syndromes are zero.
- Single data-bit error: the odd syndrome is the 12-bit complement of the even syndrome. The odd syndrome then points at the bad bit.
- Parity error: the ECC code itself took the hit, and the data is good.
- Uncorrectable: any other syndrome pattern.

The caller presents both codes on a one-cycle valid strobe. It may also present one data byte and that byte's index within the sector. One cycle after the strobe, the block returns the status, the error location and a repaired copy of that byte, along with a done pulse.

Top module: `hamming_syndrome_fix`

## Requirements
- R1: While rst_n is low, and in the cycle after it rises, res_done is 0, res_status is 0, res_byte_off is 0, res_bit_off is 0 and res_byte is 0.
- R2: The stored code is complemented before use. In each 24-bit code, bits [11:0] form the lower half and bits [23:12] form the upper half. The odd syndrome is the XOR of the lower halves, and the even syndrome is the XOR of the upper halves.
- R3: If both syndromes are zero, res_status is 0 (no error).
- R4: If the odd syndrome equals the 12-bit complement of the even syndrome, res_status is 1 (data corrected). In that case res_byte_off is odd syndrome bits [11:3] (0 to 511) and res_bit_off is odd syndrome bits [2:0].
- R5: If the R4 condition does not hold and the OR of the two syndromes has exactly one bit set, res_status is 2 (parity error). res_byte is then equal to the byte supplied.
- R6: Any syndrome pattern not covered by R3 to R5 gives res_status 3 (uncorrectable).
- R7: res_done pulses high for exactly one cycle, on the clock edge after a cycle with chk_valid high. All results change at that same edge.
- R8: res_byte equals the supplied byte with bit res_bit_off inverted, but only when the status is 1 and chk_byte_idx equals the error byte offset. Otherwise res_byte equals the supplied byte unchanged. Whenever the status is not 1, both offsets are 0.
- R9: In cycles with chk_valid low, the inputs are ignored and every result output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Strobe: evaluate the codes this cycle |
| chk_stored | input | 24 | Code as read from the spare area (inverted form) |
| chk_calc | input | 24 | Code recomputed over the read data |
| chk_byte_idx | input | 9 | Sector offset of chk_byte |
| chk_byte | input | 8 | Data byte offered for repair |
| res_done | output | 1 | One-cycle pulse when results update |
| res_status | output | 2 | 0 none, 1 data corrected, 2 parity error, 3 uncorrectable |
| res_byte_off | output | 9 | Byte offset of the bad data bit |
| res_bit_off | output | 3 | Bit offset of the bad data bit |
| res_byte | output | 8 | chk_byte, with the error bit inverted when it applies |

## Verification
Only one pipeline register sits between the strobe and the results. A wrong classification or syndrome split therefore shows up on res_status and on the offsets one cycle after the offending strobe. A wrong comparison of offsets or bit mask shows up in res_byte at that same edge. The vectors cover these cases:
- an all-ones odd syndrome and an all-zeros odd syndrome;
- a mixed pattern whose halves are complements of each other;
- a pattern with the same single bit set in both halves, which counts as a parity error;
- a byte index that misses the error byte by one.

Any update in a cycle without a strobe is caught at the very next sample.

// File: rtl/hamming_syndrome_fix.sv
module hamming_syndrome_fix #(
  parameter int HALF_W = 12,
  parameter int BIT_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_valid,
  input  logic [2*HALF_W-1:0]         chk_stored,
  input  logic [2*HALF_W-1:0]         chk_calc,
  input  logic [HALF_W-BIT_W-1:0]     chk_byte_idx,
  input  logic [(1<<BIT_W)-1:0]       chk_byte,
  output logic                        res_done,
  output logic [1:0]                  res_status,
  output logic [HALF_W-BIT_W-1:0]     res_byte_off,
  output logic [BIT_W-1:0]            res_bit_off,
  output logic [(1<<BIT_W)-1:0]       res_byte
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int OFF_W  = HALF_W - BIT_W;
  localparam int BYTE_W = 1 << BIT_W;

  logic [CODE_W-1:0] stored_true;
  logic [HALF_W-1:0] syn_odd, syn_even, syn_or;
  logic              is_zero, is_data, is_parity, hit;
  logic [1:0]        status_d;
  logic [BYTE_W-1:0] flip_mask;

  assign stored_true = ~chk_stored;
  assign syn_odd     = stored_true[HALF_W-1:0]      ^ chk_calc[HALF_W-1:0];
  assign syn_even    = stored_true[CODE_W-1:HALF_W] ^ chk_calc[CODE_W-1:HALF_W];
  assign syn_or      = syn_odd | syn_even;

  assign is_zero   = (syn_or == '0);
  assign is_data   = (syn_odd == ~syn_even);
  assign is_parity = (syn_or != '0) && ((syn_or & (syn_or - 1'b1)) == '0);

  always_comb begin
    if (is_zero)        status_d = 2'd0;
    else if (is_data)   status_d = 2'd1;
    else if (is_parity) status_d = 2'd2;
    else                status_d = 2'd3;
  end

  assign hit       = is_data && !is_zero && (chk_byte_idx == syn_odd[HALF_W-1:BIT_W]);
  assign flip_mask = hit ? (BYTE_W'(1) << syn_odd[BIT_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_done     <= 1'b0;
      res_status   <= 2'd0;
      res_byte_off <= '0;
      res_bit_off  <= '0;
      res_byte     <= '0;
    end else begin
      res_done <= chk_valid;
      if (chk_valid) begin
        res_status   <= status_d;
        res_byte_off <= (status_d == 2'd1) ? syn_odd[HALF_W-1:BIT_W] : OFF_W'(0);
        res_bit_off  <= (status_d == 2'd1) ? syn_odd[BIT_W-1:0] : BIT_W'(0);
        res_byte     <= chk_byte ^ flip_mask;
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_done);

  // R3
  clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (chk_stored == ~chk_calc)) |=> (res_status == 2'd0));

  // R8
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> ($countones(res_byte ^ $past(chk_byte)) <= 1));

  // R8
  offs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_status != 2'd1) |-> (res_byte_off == '0 && res_bit_off == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> ($stable(res_status) && $stable(res_byte) && $stable(res_byte_off)));
endmodule

// File: tb/tb_hamming_syndrome_fix.sv
module tb_hamming_syndrome_fix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chk_valid = 1'b0;
  logic [23:0] chk_stored = '0, chk_calc = '0;
  logic [8:0]  chk_byte_idx = '0;
  logic [7:0]  chk_byte = '0;
  logic        res_done;
  logic [1:0]  res_status;
  logic [8:0]  res_byte_off;
  logic [2:0]  res_bit_off;
  logic [7:0]  res_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hamming_syndrome_fix dut (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .chk_stored(chk_stored), .chk_calc(chk_calc),
    .chk_byte_idx(chk_byte_idx), .chk_byte(chk_byte),
    .res_done(res_done), .res_status(res_status),
    .res_byte_off(res_byte_off), .res_bit_off(res_bit_off),
    .res_byte(res_byte)
  );

  // Vector fields: calc[78:55] err[54:31] idx[30:22] byte[21:14] status[13:12] off[11:3] bit[2:0]
  localparam int NV = 11;
  localparam logic [78:0] VEC [NV] = '{
    {24'h123456, 24'h000000, 9'd0,   8'hA7, 2'd0, 9'd0,   3'd0},
    {24'hA5C3F0, 24'hFD402B, 9'd5,   8'h00, 2'd1, 9'd5,   3'd3},
    {24'h000000, 24'h000FFF, 9'd511, 8'hFF, 2'd1, 9'd511, 3'd7},
    {24'hFFFFFF, 24'hFFF000, 9'd0,   8'h55, 2'd1, 9'd0,   3'd0},
    {24'h0F0F0F, 24'hFD402B, 9'd6,   8'h3C, 2'd1, 9'd5,   3'd3},
    {24'h777777, 24'h000001, 9'd0,   8'h81, 2'd2, 9'd0,   3'd0},
    {24'h13579B, 24'h800000, 9'd0,   8'h42, 2'd2, 9'd0,   3'd0},
    {24'h2468AC, 24'h001001, 9'd0,   8'h99, 2'd2, 9'd0,   3'd0},
    {24'hDEADBE, 24'h000003, 9'd0,   8'h11, 2'd3, 9'd0,   3'd0},
    {24'hCAFE00, 24'h003001, 9'd0,   8'hEE, 2'd3, 9'd0,   3'd0},
    {24'h00FF00, 24'h5A5A5A, 9'd331, 8'h00, 2'd1, 9'd331, 3'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [23:0] calc, input logic [23:0] err,
                        input logic [8:0] idx, input logic [7:0] b);
    @(negedge clk);
    chk_valid    = 1'b1;
    chk_calc     = calc;
    chk_stored   = ~(calc ^ err);
    chk_byte_idx = idx;
    chk_byte     = b;
    @(negedge clk);
    chk_valid    = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(res_done), 0);
    chk("R1 status", 32'(res_status), 0);
    chk("R1 byte", 32'(res_byte), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {res_done, res_status, res_byte_off, res_bit_off, res_byte}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] eb;
      logic [1:0] es;
      logic [8:0] eo;
      logic [2:0] ebit;
      es = VEC[i][13:12];
      eo = VEC[i][11:3];
      ebit = VEC[i][2:0];
      eb = VEC[i][21:14];
      if (es == 2'd1 && VEC[i][30:22] == eo) eb = eb ^ (8'd1 << ebit);
      strobe(VEC[i][78:55], VEC[i][54:31], VEC[i][30:22], VEC[i][21:14]);
      // R2 R3 R4 R5 R6: classification per vector; R7 done one cycle later
      chk($sformatf("R7 done vec%0d", i), 32'(res_done), 1);
      chk($sformatf("R2/R3/R4/R5/R6 status vec%0d", i), 32'(res_status), 32'(es));
      chk($sformatf("R4 byte_off vec%0d", i), 32'(res_byte_off), 32'(eo));
      chk($sformatf("R4 bit_off vec%0d", i), 32'(res_bit_off), 32'(ebit));
      chk($sformatf("R8 byte vec%0d", i), 32'(res_byte), 32'(eb));
    end

    // R9: inputs change without strobe, outputs hold, done low
    @(negedge clk);
    chk_calc = 24'h000000; chk_stored = 24'h000000; chk_byte = 8'h12;
    @(negedge clk);
    chk("R7 done drops", 32'(res_done), 0);
    chk("R9 status held", 32'(res_status), 1);
    chk("R9 offset held", 32'(res_byte_off), 331);
    chk("R9 byte held", 32'(res_byte), 8'h04);

    // R7 back-to-back strobes: each result appears one edge after its strobe
    @(negedge clk);
    chk_valid = 1'b1; chk_calc = 24'h111111; chk_stored = ~24'h111111; chk_byte = 8'hAA;
    @(negedge clk);
    chk("R3 back-to-back first", 32'(res_status), 0);
    chk_calc = 24'h111111; chk_stored = ~(24'h111111 ^ 24'h000003); chk_byte = 8'hBB;
    @(negedge clk);
    chk_valid = 1'b0;
    chk("R6 back-to-back second", 32'(res_status), 3);
    chk("R7 done held on consecutive", 32'(res_done), 1);
    chk("R8 byte passthrough uncorrectable", 32'(res_byte), 8'hBB);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", {res_status, res_byte}, 0);
    rst_n = 1'b1;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule